// File: doc/BRIEF.md
# Descriptor-Driven Transfer Step Engine

This block carries out one step of a peripheral-triggered memory copy. When an arbiter grants a channel, the engine loads that channel's 64-bit descriptor. The descriptor holds a buffer pointer, a control byte, an I/O pointer confined to the lowest 64 KiB, and a remaining count. The engine moves one byte or one 16-bit word between the I/O side and the buffer side over a simple strobe-and-ready memory bus. It then returns the updated descriptor so that the channel store can save it.

Each side is handled according to its own address. If a word lands on an odd address on one side, that side is served as two byte accesses, lower address first, while an even side keeps a single word access. A word request with only one unit left becomes a byte step. A count of zero is read as the full 65536-unit length. A peripheral may abort a step through a stop input, provided the descriptor enables that.

Descriptor packing on `desc_in` and `desc_out`, from bit 0 upward: buffer pointer [23:0], control byte [31:24], I/O pointer [47:32], count [63:48]. Control byte bits:

- bit 5: buffer pointer steps downward
- bit 4: I/O pointer held
- bit 3: word mode
- bit 2: buffer pointer held
- bit 1: direction (0 means I/O to buffer, 1 means buffer to I/O)
- bit 0: stop enable
- bits 7..6: reserved

Top module: `dma_step_engine`

## Requirements
- R1: A byte step reads one byte from the source and writes it to the destination. Bytes always travel on data bits [7:0], and write data bits [15:8] are 0. The step decrements the count by 1 and moves each pointer that is not held by 1.
- R2: In word mode with both addresses even, the step makes one word read (`mem_word`=1) and then one word write carrying the same 16 bits. It decrements the count by 2 and moves each pointer that is not held by 2.
- R3: A word whose address on one side is odd is split on that side into two byte accesses. The first is at the address itself and carries the low byte; the second is at the address plus one and carries the high byte. A word access is never issued at an odd address.
- R4: Word mode with a count of exactly 1 makes a single byte step, and the count becomes 0.
- R5: A starting count of 0 is treated as the maximum length. The step goes ahead, and the count becomes 0xFFFF in byte mode or 0xFFFE in word mode, with no end reported.
- R6: Direction 0 reads the I/O pointer and writes the buffer pointer; direction 1 does the reverse. Bus addresses on the I/O side have bits 23..16 at 0. The two hold bits keep their pointers unchanged.
- R7: When control bit 5 is set, the buffer pointer moves down by the step size instead of up.
- R8: The I/O pointer wraps within 16 bits and the buffer pointer within 24 bits, both for the second access of a split and for the post-step update.
- R9: If stop enable is set and `stop_req` is high during the read phase of a step, the step aborts. No write is issued, `stopped` pulses for one cycle and no `step_done` follows. With stop enable clear, or during the write phase, `stop_req` has no effect.
- R10: One cycle after the last write is accepted, `step_done` pulses together with the updated descriptor on `desc_out`, with reserved bits 7..6 of the control byte at 0. `xfer_end` is high in that cycle exactly when the new count is 0.
- R11: A strobe stays high, with its address and write data unchanged, until `mem_ready` is high. A `grant` that arrives while `busy` is high is ignored.
- R12: After reset the engine is idle, with `busy`, both strobes, `step_done` and `stopped` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | Start one step with `desc_in` (taken only when idle) |
| desc_in | input | 64 | Descriptor of the granted channel |
| stop_req | input | 1 | Abort request from the peripheral |
| busy | output | 1 | A step is in progress |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_word | output | 1 | 1 for a 16-bit access, 0 for a byte access |
| mem_addr | output | 24 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Completes the current access |
| step_done | output | 1 | One-cycle pulse when a step finishes |
| xfer_end | output | 1 | With `step_done`: the count has reached 0 |
| stopped | output | 1 | One-cycle pulse when a step is aborted |
| desc_out | output | 64 | Updated descriptor, valid with `step_done` |

## Verification
Stop handling and end-of-count reporting can meet in the same step. The bench provokes this by raising `stop_req` with stop enabled only once a write strobe of a final, count-reaching-zero step is seen under wait states. It judges the result by requiring a normal `step_done` with `xfer_end` and no `stopped`. A second case raises the stop before the first read and expects an abort with no write at all. The vector table is replayed with one wait state per access, so that every split order and pointer update is also seen with stalled strobes.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int CNT_W  = 16;
    localparam int IO_W   = 16;
    localparam int BUF_W  = 24;
    localparam int DAT_W  = 16;
    localparam int DESC_W = CNT_W + IO_W + 8 + BUF_W;

    // control byte bit positions
    localparam int C_DEC    = 5;
    localparam int C_IOHOLD = 4;
    localparam int C_WORD   = 3;
    localparam int C_BFHOLD = 2;
    localparam int C_DIR    = 1;
    localparam int C_STOPEN = 0;
    localparam logic [7:0] C_KEEP = 8'h3F;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [IO_W-1:0]  io;
        logic [7:0]       ctl;
        logic [BUF_W-1:0] bufa;
    } desc_t;

    typedef struct packed {
        logic             wide;
        logic             src_split;
        logic             dst_split;
        logic [BUF_W-1:0] src_a;
        logic [BUF_W-1:0] src_a2;
        logic [BUF_W-1:0] dst_a;
        logic [BUF_W-1:0] dst_a2;
    } plan_t;

    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_RD1, S_WR0, S_WR1, S_FIN, S_ABT
    } seq_st_t;

    function automatic logic [BUF_W-1:0] io_to_bus(input logic [IO_W-1:0] a);
        return {{(BUF_W-IO_W){1'b0}}, a};
    endfunction

endpackage

// File: rtl/dma_step_plan.sv
module dma_step_plan
    import dma_eng_pkg::*;
(
    input  desc_t d,
    output plan_t pl,
    output desc_t nxt,
    output logic  last
);
    logic             wide;
    logic [CNT_W-1:0] stepv;
    logic [BUF_W-1:0] io_a, io_a2, bf_a, bf_a2;
    logic             to_io;

    always_comb begin
        wide  = d.ctl[C_WORD] && (d.cnt != CNT_W'(1));
        stepv = wide ? CNT_W'(2) : CNT_W'(1);
        to_io = d.ctl[C_DIR];
        io_a  = io_to_bus(d.io);
        io_a2 = io_to_bus(d.io + IO_W'(1));
        bf_a  = d.bufa;
        bf_a2 = d.bufa + BUF_W'(1);

        pl.wide   = wide;
        pl.src_a  = to_io ? bf_a  : io_a;
        pl.src_a2 = to_io ? bf_a2 : io_a2;
        pl.dst_a  = to_io ? io_a  : bf_a;
        pl.dst_a2 = to_io ? io_a2 : bf_a2;
        pl.src_split = wide && pl.src_a[0];
        pl.dst_split = wide && pl.dst_a[0];

        nxt.cnt = d.cnt - stepv;
        nxt.ctl = d.ctl & C_KEEP;
        nxt.io  = d.ctl[C_IOHOLD] ? d.io : d.io + IO_W'(stepv);
        if (d.ctl[C_BFHOLD])
            nxt.bufa = d.bufa;
        else if (d.ctl[C_DEC])
            nxt.bufa = d.bufa - BUF_W'(stepv);
        else
            nxt.bufa = d.bufa + BUF_W'(stepv);
        last = (nxt.cnt == '0);
    end
endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
    import dma_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop_en,
    input  logic             stop_req,
    input  plan_t            pl,
    input  logic             mem_ready,
    input  logic [DAT_W-1:0] mem_rdata,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             mem_word,
    output logic [BUF_W-1:0] mem_addr,
    output logic [DAT_W-1:0] mem_wdata,
    output logic             fin,
    output logic             abort,
    output logic             busy
);
    seq_st_t          st, st_n;
    logic [DAT_W-1:0] dat;
    logic             kill;

    assign kill = stop_en && stop_req;

    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE: if (start) st_n = S_RD0;
            S_RD0: begin
                if (kill)           st_n = S_ABT;
                else if (mem_ready) st_n = pl.src_split ? S_RD1 : S_WR0;
            end
            S_RD1: begin
                if (kill)           st_n = S_ABT;
                else if (mem_ready) st_n = S_WR0;
            end
            S_WR0: if (mem_ready) st_n = pl.dst_split ? S_WR1 : S_FIN;
            S_WR1: if (mem_ready) st_n = S_FIN;
            S_FIN: st_n = S_IDLE;
            S_ABT: st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            dat <= '0;
        end else begin
            st <= st_n;
            if (st == S_RD0 && mem_ready && !kill) begin
                if (pl.src_split)  dat[7:0] <= mem_rdata[7:0];
                else if (pl.wide)  dat      <= mem_rdata;
                else               dat      <= {8'h00, mem_rdata[7:0]};
            end
            if (st == S_RD1 && mem_ready && !kill)
                dat[15:8] <= mem_rdata[7:0];
        end
    end

    always_comb begin
        mem_rd    = (st == S_RD0) || (st == S_RD1);
        mem_wr    = (st == S_WR0) || (st == S_WR1);
        mem_word  = ((st == S_RD0) && pl.wide && !pl.src_split) ||
                    ((st == S_WR0) && pl.wide && !pl.dst_split);
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st)
            S_RD0: mem_addr = pl.src_a;
            S_RD1: mem_addr = pl.src_a2;
            S_WR0: begin
                mem_addr  = pl.dst_a;
                mem_wdata = (pl.wide && !pl.dst_split) ? dat : {8'h00, dat[7:0]};
            end
            S_WR1: begin
                mem_addr  = pl.dst_a2;
                mem_wdata = {8'h00, dat[15:8]};
            end
            default: ;
        endcase
        fin   = (st == S_FIN);
        abort = (st == S_ABT);
        busy  = (st != S_IDLE);
    end

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R3
    word_even_chk: assert property (@(posedge clk) disable iff (rst)
        mem_word |-> !mem_addr[0]);

    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R9
    abort_gate_chk: assert property (@(posedge clk) disable iff (rst)
        abort |-> stop_en);
endmodule

// File: rtl/dma_step_engine.sv
module dma_step_engine
    import dma_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              grant,
    input  logic [DESC_W-1:0] desc_in,
    input  logic              stop_req,
    output logic              busy,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_word,
    output logic [BUF_W-1:0]  mem_addr,
    output logic [DAT_W-1:0]  mem_wdata,
    input  logic [DAT_W-1:0]  mem_rdata,
    input  logic              mem_ready,
    output logic              step_done,
    output logic              xfer_end,
    output logic              stopped,
    output logic [DESC_W-1:0] desc_out
);
    desc_t cur, nxt;
    plan_t pl;
    logic  last, start;

    assign start = grant && !busy;

    always_ff @(posedge clk) begin
        if (rst)        cur <= '0;
        else if (start) cur <= desc_t'(desc_in);
    end

    dma_step_plan u_plan (
        .d    (cur),
        .pl   (pl),
        .nxt  (nxt),
        .last (last)
    );

    dma_bus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop_en   (cur.ctl[C_STOPEN]),
        .stop_req  (stop_req),
        .pl        (pl),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_word  (mem_word),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .fin       (step_done),
        .abort     (stopped),
        .busy      (busy)
    );

    assign xfer_end = step_done && last;
    assign desc_out = nxt;

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        step_done |-> (desc_out[31:30] == 2'b00));

    // R11
    regrant_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && grant) |=> $stable(cur));

    // R9
    stop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        stopped |-> $past(stop_req));

    // R12
    idle_after_rst_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !mem_rd && !mem_wr));
endmodule

// File: tb/dma_step_engine_test.sv
module dma_step_engine_test;
    typedef struct packed {
        logic        wr;
        logic        wd;
        logic [23:0] a;
        logic [15:0] d;
    } acc_t;

    typedef struct packed {
        logic [63:0]     din;
        logic [2:0]      n;
        acc_t [0:3]      acc;
        logic [63:0]     dout;
        logic            fin;
        logic [3:0]      rq;
    } vec_t;

    localparam acc_t NA = '{1'b0, 1'b0, 24'h0, 16'h0};
    localparam int NV = 11;
    // R1 R2 R3 R4 R5 R6 R7 R8 R10 vectors; read data at byte address x is x[7:0]+0x11
    localparam vec_t VT [NV] = '{
        '{64'h0008_1234_10_400010, 3'd2, '{'{1'b0,1'b0,24'h001234,16'h0}, '{1'b1,1'b0,24'h400010,16'h0045}, NA, NA}, 64'h0007_1234_10_400011, 1'b0, 4'd1},
        '{64'h0006_0100_0A_012340, 3'd2, '{'{1'b0,1'b1,24'h012340,16'h0}, '{1'b1,1'b1,24'h000100,16'h5251}, NA, NA}, 64'h0004_0102_0A_012342, 1'b0, 4'd2},
        '{64'h0004_0201_08_000800, 3'd3, '{'{1'b0,1'b0,24'h000201,16'h0}, '{1'b0,1'b0,24'h000202,16'h0}, '{1'b1,1'b1,24'h000800,16'h1312}, NA}, 64'h0002_0203_08_000802, 1'b0, 4'd3},
        '{64'h0001_0010_08_000020, 3'd2, '{'{1'b0,1'b0,24'h000010,16'h0}, '{1'b1,1'b0,24'h000020,16'h0021}, NA, NA}, 64'h0000_0011_08_000021, 1'b1, 4'd4},
        '{64'h0000_0030_00_000040, 3'd2, '{'{1'b0,1'b0,24'h000030,16'h0}, '{1'b1,1'b0,24'h000040,16'h0041}, NA, NA}, 64'hFFFF_0031_00_000041, 1'b0, 4'd5},
        '{64'h0000_0050_08_000060, 3'd2, '{'{1'b0,1'b1,24'h000050,16'h0}, '{1'b1,1'b1,24'h000060,16'h6261}, NA, NA}, 64'hFFFE_0052_08_000062, 1'b0, 4'd5},
        '{64'h0002_0070_28_000091, 3'd3, '{'{1'b0,1'b1,24'h000070,16'h0}, '{1'b1,1'b0,24'h000091,16'h0081}, '{1'b1,1'b0,24'h000092,16'h0082}, NA}, 64'h0000_0072_28_00008F, 1'b1, 4'd7},
        '{64'h0003_FFFF_00_FFFFFF, 3'd2, '{'{1'b0,1'b0,24'h00FFFF,16'h0}, '{1'b1,1'b0,24'hFFFFFF,16'h0010}, NA, NA}, 64'h0002_0000_00_000000, 1'b0, 4'd8},
        '{64'h000A_00B5_1E_1000A3, 3'd4, '{'{1'b0,1'b0,24'h1000A3,16'h0}, '{1'b0,1'b0,24'h1000A4,16'h0}, '{1'b1,1'b0,24'h0000B5,16'h00B4}, '{1'b1,1'b0,24'h0000B6,16'h00B5}}, 64'h0008_00B5_1E_1000A3, 1'b0, 4'd6},
        '{64'h0004_FFFF_08_000200, 3'd3, '{'{1'b0,1'b0,24'h00FFFF,16'h0}, '{1'b0,1'b0,24'h000000,16'h0}, '{1'b1,1'b1,24'h000200,16'h1110}, NA}, 64'h0002_0001_08_000202, 1'b0, 4'd8},
        '{64'h0002_0005_C0_000006, 3'd2, '{'{1'b0,1'b0,24'h000005,16'h0}, '{1'b1,1'b0,24'h000006,16'h0016}, NA, NA}, 64'h0001_0006_00_000007, 1'b0, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        grant = 1'b0;
    logic [63:0] desc_in = '0;
    logic        stop_req = 1'b0;
    logic        busy, mem_rd, mem_wr, mem_word, mem_ready;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        step_done, xfer_end, stopped;
    logic [63:0] desc_out;

    dma_step_engine uut (
        .clk(clk), .rst(rst), .grant(grant), .desc_in(desc_in), .stop_req(stop_req),
        .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .step_done(step_done), .xfer_end(xfer_end),
        .stopped(stopped), .desc_out(desc_out)
    );

    always #4 clk = ~clk;

    // bus model: optional one wait state per access
    logic wait_mode = 1'b0;
    logic ph;
    always @(posedge clk) begin
        if (rst) ph <= 1'b0;
        else if (mem_rd || mem_wr) ph <= ~ph;
        else ph <= 1'b0;
    end
    always_comb begin
        mem_ready = wait_mode ? ph : 1'b1;
        if (mem_word) mem_rdata = {mem_addr[7:0] + 8'h12, mem_addr[7:0] + 8'h11};
        else          mem_rdata = {8'h00, mem_addr[7:0] + 8'h11};
    end

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    acc_t lg [4];
    int nacc, nwr;
    logic got_done, got_stop, got_end;
    logic [63:0] got_out;
    logic stop_on_wr = 1'b0;
    logic regrant = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_step(input logic [63:0] d);
        nacc = 0; nwr = 0; got_done = 0; got_stop = 0; got_end = 0; got_out = '0;
        @(negedge clk); desc_in = d; grant = 1'b1;
        @(negedge clk); grant = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (regrant && c == 1) begin grant = 1'b1; desc_in = 64'hFFFF_FFFF_3F_FFFFFF; end
            else grant = 1'b0;
            if (mem_wr && stop_on_wr) stop_req = 1'b1;
            if ((mem_rd || mem_wr) && mem_ready) begin
                if (nacc < 4) lg[nacc] = '{mem_wr, mem_word, mem_addr, mem_wr ? mem_wdata : 16'h0};
                nacc++;
                if (mem_wr) nwr++;
            end
            if (step_done) begin got_done = 1; got_end = xfer_end; got_out = desc_out; end
            if (stopped) got_stop = 1;
            if (step_done || stopped) break;
            @(negedge clk);
        end
        grant = 1'b0;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    initial begin
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk(!busy && !mem_rd && !mem_wr && !step_done && !stopped, "R12 idle after reset",
            {59'h0, busy, mem_rd, mem_wr, step_done, stopped}, 64'h0);

        for (int pass = 0; pass < 2; pass++) begin
            wait_mode = (pass == 1);
            for (int v = 0; v < NV; v++) begin
                string tag;
                tag = $sformatf("R%0d vec%0d pass%0d", VT[v].rq, v, pass);
                do_step(VT[v].din);
                chk(nacc == int'(VT[v].n), {tag, " access count"}, 64'(nacc), 64'(VT[v].n));
                for (int i = 0; i < 4; i++)
                    if (i < int'(VT[v].n) && i < nacc)
                        chk(lg[i] == VT[v].acc[i], $sformatf("%s access %0d", tag, i),
                            64'(lg[i]), 64'(VT[v].acc[i]));
                chk(got_done && !got_stop, {tag, " step_done"}, {62'h0, got_done, got_stop}, 64'h2);
                chk(got_out == VT[v].dout, {tag, " desc_out"}, got_out, VT[v].dout);
                chk(got_end == VT[v].fin, {tag, " xfer_end"}, 64'(got_end), 64'(VT[v].fin));
            end
        end

        // R9 stop before the first read completes: abort, no write
        wait_mode = 1'b0;
        @(negedge clk); stop_req = 1'b1;
        do_step(64'h0005_0040_01_000500);
        chk(got_stop && !got_done, "R9 abort pulse", {62'h0, got_stop, got_done}, 64'h2);
        chk(nwr == 0, "R9 no write on abort", 64'(nwr), 64'h0);

        // R9 stop with enable clear is ignored
        @(negedge clk); stop_req = 1'b1;
        do_step(VT[0].din);
        chk(got_done && !got_stop, "R9 stop ignored when disabled", {62'h0, got_done, got_stop}, 64'h2);
        chk(got_out == VT[0].dout, "R9 desc_out unaffected", got_out, VT[0].dout);

        // R9 R10 stop in write phase of final step: completes with end, no abort
        wait_mode = 1'b1; stop_on_wr = 1'b1;
        do_step(64'h0002_0100_09_000300);
        stop_on_wr = 1'b0;
        chk(got_done && got_end && !got_stop, "R9 write-phase stop ignored",
            {61'h0, got_done, got_end, got_stop}, 64'h6);
        chk(got_out == 64'h0000_0102_09_000302, "R10 final descriptor", got_out, 64'h0000_0102_09_000302);
        chk(nwr == 1 && lg[1].d == 16'h1211, "R10 final write data", 64'(lg[1].d), 64'h1211);

        // R11 grant while busy is ignored
        regrant = 1'b1;
        do_step(VT[1].din);
        regrant = 1'b0;
        chk(got_out == VT[1].dout, "R11 regrant ignored", got_out, VT[1].dout);
        chk(nacc == 2, "R11 access count", 64'(nacc), 64'h2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule